// File: doc/BRIEF.md
# Streaming Welch t-Test Leakage Assessor

This block decides whether a device under test leaks secret-dependent information through its power draw. Trace samples stream in one at a time. Each sample carries its position within the trace and a flag that names its population. One population is recorded with a constant key and a constant input. The other is recorded with the same key and varying inputs. For every position and population, the block keeps a running count, sum and sum of squares in registers.

When a compute command arrives, the block visits every position in turn. At each position it applies Welch's two-sample test at the 4.5 threshold. The test is rewritten as an exact integer inequality, so the block needs neither a square root nor a divider. At the end of the walk it pulses done. It reports a failing verdict if any position crossed the threshold, together with the lowest position that did. A synchronous clear empties every accumulator so that a new campaign can start.

Top module: `leak_ttest_unit`

## Requirements
- R1: After reset, `done`, `busy` and `fail` are 0 and `fail_idx` is 0.
- R2: A sample accepted while idle (`in_valid`=1, `in_idx` < NUM_IDX) is added to the accumulators of position `in_idx` and population `in_cls`. `in_cls`=0 selects the constant-input population and `in_cls`=1 selects the varying-input population.
- R3: With counts Nf and Nr, sums Sf and Sr, and Qx = Nx·Σx² − Sx², let D = Sf·Nr − Sr·Nf. A position is flagged when 4·D²·(Nf−1)·(Nr−1) > 81·(Qf·Nr²·(Nr−1) + Qr·Nf²·(Nf−1)). This equals |t| > 4.5 with unbiased variances, and the comparison is strict.
- R4: A position where either population holds fewer than two samples is never flagged.
- R5: `fail` is 1 exactly when at least one position is flagged. `fail_idx` is then the lowest flagged position, and it is 0 on a pass.
- R6: A `start` taken while idle raises `busy` for exactly NUM_IDX cycles. `done` is then high for one cycle, the first cycle in which `busy` is low.
- R7: While `busy` is high, `in_valid`, `clr` and `start` have no effect.
- R8: `clr` taken while idle zeroes every count, sum and sum of squares.
- R9: Once a position and population holds 2^CNT_W−1 samples, further samples for that pair are dropped.
- R10: `fail` and `fail_idx` keep their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero all accumulators |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Unsigned sample value |
| in_idx | input | IDX_W | Position within the trace |
| in_cls | input | 1 | Population: 0 constant input, 1 varying input |
| start | input | 1 | Begin the walk over all positions |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| fail | output | 1 | At least one position crossed the threshold |
| fail_idx | output | IDX_W | Lowest crossing position |

## Verification
The hardest situations to reach from the ports are the ones near the decision edge. One is a pair of positions whose statistics sit on either side of 4.5, where the difference comes only from the strict integer comparison. The bench builds these from two-sample populations with hand-chosen values. It also reaches the count ceiling by streaming more than a thousand samples into one position. A reference model written with real-valued means, variances and a square root judges every verdict. It covers same-distribution noise, a single injected mean shift, two shifts where the lower one must be reported, and positions that hold too few samples.

// File: rtl/ttest_pkg.sv
package ttest_pkg;
  localparam int unsigned CLS_CONST = 0;
  localparam int unsigned CLS_VARY  = 1;
  localparam int unsigned NUM_CLS   = 2;
  localparam int unsigned THR_LHS_K = 4;
  localparam int unsigned THR_RHS_K = 81;
  typedef enum logic {ST_IDLE = 1'b0, ST_WALK = 1'b1} walk_state_e;
endpackage

// File: rtl/ttest_acc_bank.sv
module ttest_acc_bank #(
  parameter int SAMPLE_W = 8,
  parameter int NUM_IDX  = 16,
  parameter int CNT_W    = 10,
  localparam int IDX_W   = $clog2(NUM_IDX),
  localparam int SUM_W   = SAMPLE_W + CNT_W,
  localparam int SQ_W    = 2 * SAMPLE_W + CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                we,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_cls,
  input  logic [SAMPLE_W-1:0] wr_x,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [CNT_W-1:0]    nf,
  output logic [CNT_W-1:0]    nr,
  output logic [SUM_W-1:0]    sf,
  output logic [SUM_W-1:0]    sr,
  output logic [SQ_W-1:0]     qf,
  output logic [SQ_W-1:0]     qr
);
  import ttest_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM_CLS][NUM_IDX];
  logic [SUM_W-1:0] sum_q [NUM_CLS][NUM_IDX];
  logic [SQ_W-1:0]  sq_q  [NUM_CLS][NUM_IDX];

  logic [SQ_W-1:0] x_sq;
  logic            room;
  assign x_sq = SQ_W'(wr_x) * SQ_W'(wr_x);
  assign room = (cnt_q[wr_cls][wr_idx] != CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int c = 0; c < NUM_CLS; c++) begin
        for (int i = 0; i < NUM_IDX; i++) begin
          cnt_q[c][i] <= '0;
          sum_q[c][i] <= '0;
          sq_q[c][i]  <= '0;
        end
      end
    end else if (we && room) begin
      cnt_q[wr_cls][wr_idx] <= cnt_q[wr_cls][wr_idx] + 1'b1;
      sum_q[wr_cls][wr_idx] <= sum_q[wr_cls][wr_idx] + SUM_W'(wr_x);
      sq_q[wr_cls][wr_idx]  <= sq_q[wr_cls][wr_idx] + x_sq;
    end
  end

  assign nf = cnt_q[CLS_CONST][rd_idx];
  assign nr = cnt_q[CLS_VARY][rd_idx];
  assign sf = sum_q[CLS_CONST][rd_idx];
  assign sr = sum_q[CLS_VARY][rd_idx];
  assign qf = sq_q[CLS_CONST][rd_idx];
  assign qr = sq_q[CLS_VARY][rd_idx];
endmodule

// File: rtl/ttest_welch_cmp.sv
module ttest_welch_cmp #(
  parameter int SAMPLE_W = 8,
  parameter int CNT_W    = 10,
  localparam int SUM_W   = SAMPLE_W + CNT_W,
  localparam int SQ_W    = 2 * SAMPLE_W + CNT_W,
  localparam int WIDE_W  = 2 * (SUM_W + CNT_W) + 2 * CNT_W + 8
) (
  input  logic [CNT_W-1:0] nf,
  input  logic [CNT_W-1:0] nr,
  input  logic [SUM_W-1:0] sf,
  input  logic [SUM_W-1:0] sr,
  input  logic [SQ_W-1:0]  qf,
  input  logic [SQ_W-1:0]  qr,
  output logic             eligible,
  output logic             over_thr
);
  import ttest_pkg::*;

  // Centred second moment scaled by N^2: N*sum(x^2) - (sum x)^2
  function automatic logic [WIDE_W-1:0] spread(input logic [CNT_W-1:0] n,
                                               input logic [SUM_W-1:0] s,
                                               input logic [SQ_W-1:0]  q);
    return WIDE_W'(n) * WIDE_W'(q) - WIDE_W'(s) * WIDE_W'(s);
  endfunction

  // Squared-and-cross-multiplied Welch criterion, strict comparison
  function automatic logic welch_exceeds(input logic [CNT_W-1:0] a_n,
                                         input logic [CNT_W-1:0] b_n,
                                         input logic [SUM_W-1:0] a_s,
                                         input logic [SUM_W-1:0] b_s,
                                         input logic [SQ_W-1:0]  a_q,
                                         input logic [SQ_W-1:0]  b_q);
    logic [WIDE_W-1:0] cross_a, cross_b, dmag, lhs, rhs, sa, sb, na, nb;
    na      = WIDE_W'(a_n);
    nb      = WIDE_W'(b_n);
    cross_a = WIDE_W'(a_s) * nb;
    cross_b = WIDE_W'(b_s) * na;
    dmag    = (cross_a > cross_b) ? cross_a - cross_b : cross_b - cross_a;
    sa      = spread(a_n, a_s, a_q);
    sb      = spread(b_n, b_s, b_q);
    lhs     = WIDE_W'(THR_LHS_K) * dmag * dmag * (na - 1) * (nb - 1);
    rhs     = WIDE_W'(THR_RHS_K) * (sa * nb * nb * (nb - 1) + sb * na * na * (na - 1));
    return lhs > rhs;
  endfunction

  assign eligible = (nf >= CNT_W'(2)) && (nr >= CNT_W'(2));
  assign over_thr = eligible && welch_exceeds(nf, nr, sf, sr, qf, qr);
endmodule

// File: rtl/ttest_walk_ctrl.sv
module ttest_walk_ctrl #(
  parameter int NUM_IDX = 16,
  localparam int IDX_W  = $clog2(NUM_IDX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit,
  output logic             busy,
  output logic             last,
  output logic [IDX_W-1:0] walk_idx,
  output logic             done,
  output logic             fail,
  output logic [IDX_W-1:0] fail_idx
);
  import ttest_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IDX - 1);

  walk_state_e      st_q;
  logic             seen_q;
  logic [IDX_W-1:0] first_q;
  logic             seen_nx;
  logic [IDX_W-1:0] first_nx;

  assign busy     = (st_q == ST_WALK);
  assign last     = busy && (walk_idx == LAST_IDX);
  assign seen_nx  = seen_q || hit;
  assign first_nx = (hit && !seen_q) ? walk_idx : first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      walk_idx <= '0;
      seen_q   <= 1'b0;
      first_q  <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      fail_idx <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q     <= ST_WALK;
          walk_idx <= '0;
          seen_q   <= 1'b0;
          first_q  <= '0;
        end
        ST_WALK: begin
          seen_q  <= seen_nx;
          first_q <= first_nx;
          if (last) begin
            st_q     <= ST_IDLE;
            done     <= 1'b1;
            fail     <= seen_nx;
            fail_idx <= seen_nx ? first_nx : '0;
          end else begin
            walk_idx <= walk_idx + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/leak_ttest_unit.sv
module leak_ttest_unit #(
  parameter int SAMPLE_W = 8,
  parameter int NUM_IDX  = 16,
  parameter int CNT_W    = 10,
  localparam int IDX_W   = $clog2(NUM_IDX),
  localparam int SUM_W   = SAMPLE_W + CNT_W,
  localparam int SQ_W    = 2 * SAMPLE_W + CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [IDX_W-1:0]    in_idx,
  input  logic                in_cls,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [IDX_W-1:0]    fail_idx
);
  logic             acc_we;
  logic             clr_eff;
  logic             start_eff;
  logic             scan_hit;
  logic             scan_ok;
  logic             scan_last;
  logic [IDX_W-1:0] scan_idx;
  logic [CNT_W-1:0] nf, nr;
  logic [SUM_W-1:0] sf, sr;
  logic [SQ_W-1:0]  qf, qr;

  assign acc_we    = in_valid && !busy && (int'(in_idx) < NUM_IDX);
  assign clr_eff   = clr && !busy;
  assign start_eff = start && !busy;

  ttest_acc_bank #(.SAMPLE_W(SAMPLE_W), .NUM_IDX(NUM_IDX), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr_eff), .we(acc_we),
    .wr_idx(in_idx), .wr_cls(in_cls), .wr_x(in_sample), .rd_idx(scan_idx),
    .nf(nf), .nr(nr), .sf(sf), .sr(sr), .qf(qf), .qr(qr)
  );

  ttest_welch_cmp #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_cmp (
    .nf(nf), .nr(nr), .sf(sf), .sr(sr), .qf(qf), .qr(qr),
    .eligible(scan_ok), .over_thr(scan_hit)
  );

  ttest_walk_ctrl #(.NUM_IDX(NUM_IDX)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_eff), .hit(scan_hit && busy),
    .busy(busy), .last(scan_last), .walk_idx(scan_idx),
    .done(done), .fail(fail), .fail_idx(fail_idx)
  );
endmodule

// File: rtl/leak_ttest_sva.sv
module leak_ttest_sva #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             acc_we,
  input logic             scan_ok,
  input logic             scan_hit,
  input logic             scan_last,
  input logic             fail,
  input logic [IDX_W-1:0] fail_idx
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_start_enters_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_no_write_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc_we);
  assert_skip_small_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_ok |-> !scan_hit);
  assert_last_hit_fails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_last && scan_hit) |=> (fail && done));
  assert_verdict_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(fail) && $stable(fail_idx)));
endmodule

bind leak_ttest_unit leak_ttest_sva #(.IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .acc_we(acc_we), .scan_ok(scan_ok), .scan_hit(scan_hit),
  .scan_last(scan_last), .fail(fail), .fail_idx(fail_idx)
);

// File: tb/leak_ttest_unit_tb.sv
module leak_ttest_unit_tb;
  localparam int SW = 8, NI = 16, CW = 10, IW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, clr = 0, in_valid = 0, in_cls = 0, start = 0;
  logic [SW-1:0] in_sample = '0;
  logic [IW-1:0] in_idx = '0;
  logic busy, done, fail;
  logic [IW-1:0] fail_idx;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic [15:0] rng = 16'hACE1;
  real rc[2][NI], rs[2][NI], rq[2][NI];

  always #4 clk = ~clk;

  leak_ttest_unit #(.SAMPLE_W(SW), .NUM_IDX(NI), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_sample(in_sample),
    .in_idx(in_idx), .in_cls(in_cls), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_idx(fail_idx));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] noise();
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
    return rng[3:0];
  endfunction

  task automatic ref_clear();
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < NI; i++) begin rc[c][i] = 0; rs[c][i] = 0; rq[c][i] = 0; end
  endtask

  // Real-valued Welch test over the bench's own accumulators
  task automatic ref_verdict(output int ef, output int ei);
    ef = 0; ei = 0;
    for (int i = NI - 1; i >= 0; i--) begin
      real mf, mr, vf, vr, den, t;
      if (rc[0][i] < 2 || rc[1][i] < 2) continue;
      mf = rs[0][i] / rc[0][i];
      mr = rs[1][i] / rc[1][i];
      vf = (rq[0][i] - rs[0][i] * mf) / (rc[0][i] - 1);
      vr = (rq[1][i] - rs[1][i] * mr) / (rc[1][i] - 1);
      den = vf / rc[0][i] + vr / rc[1][i];
      if (den <= 0.0) begin
        if (mf != mr) begin ef = 1; ei = i; end
      end else begin
        t = (mf - mr) / $sqrt(den);
        if (t > 4.5 || t < -4.5) begin ef = 1; ei = i; end
      end
    end
  endtask

  task automatic push(input int idx, input int cls, input int x);
    @(negedge clk);
    in_valid = 1; in_idx = IW'(idx); in_cls = cls[0]; in_sample = SW'(x);
    if (rc[cls][idx] < CMAX) begin
      rc[cls][idx] += 1; rs[cls][idx] += x; rq[cls][idx] += real'(x) * x;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; clr = 0; start = 0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    in_valid = 0; clr = 1;
    ref_clear();
    idle();
  endtask

  // Start a walk, check its length and pulse, then compare with the model
  task automatic run_scan(input string tag);
    int n, ef, ei;
    idle();
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check({tag, " R6 busy length"}, n, NI);
    check({tag, " R6 done pulse"}, int'(done), 1);
    ref_verdict(ef, ei);
    check({tag, " R5 fail"}, int'(fail), ef);
    check({tag, " R5 fail_idx"}, int'(fail_idx), ei);
    @(negedge clk);
    check({tag, " R6 done single"}, int'(done), 0);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 fail", int'(fail), 0);
    check("R1 fail_idx", int'(fail_idx), 0);
  endtask

  task automatic t_same_dist();
    do_clear();
    for (int k = 0; k < 40; k++)
      for (int i = 0; i < NI; i++) begin
        push(i, 0, 120 + noise());
        push(i, 1, 120 + noise());
      end
    run_scan("same R2");
    check("same R5 pass expected", int'(fail), 0);
  endtask

  task automatic t_one_shift();
    do_clear();
    for (int k = 0; k < 40; k++)
      for (int i = 0; i < NI; i++) begin
        push(i, 0, 120 + noise() + ((i == 5) ? 20 : 0));
        push(i, 1, 120 + noise());
      end
    run_scan("shift R3");
    check("shift R5 index 5", int'(fail_idx), 5);
  endtask

  task automatic t_two_shifts();
    do_clear();
    for (int k = 0; k < 30; k++)
      for (int i = 0; i < NI; i++) begin
        push(i, 0, 60 + noise() + ((i == 3 || i == 9) ? 25 : 0));
        push(i, 1, 60 + noise());
      end
    run_scan("two R5");
    check("two R5 lowest 3", int'(fail_idx), 3);
  endtask

  // t = 4.24 at position 1 (not flagged), t = 4.95 at position 7 (flagged)
  task automatic t_edge();
    do_clear();
    push(1, 0, 10); push(1, 0, 12); push(1, 1, 16); push(1, 1, 18);
    push(7, 0, 10); push(7, 0, 12); push(7, 1, 17); push(7, 1, 19);
    run_scan("edge R3");
    check("edge R3 flag at 7", int'(fail_idx), 7);
  endtask

  task automatic t_small();
    do_clear();
    push(2, 0, 250);
    for (int k = 0; k < 20; k++) push(2, 1, 10 + noise());
    push(6, 1, 250);
    for (int k = 0; k < 20; k++) push(6, 0, 10 + noise());
    run_scan("small R4");
    check("small R4 pass", int'(fail), 0);
    push(4, 0, 200); push(4, 0, 200);
    for (int k = 0; k < 10; k++) push(4, 1, 120 + noise());
    run_scan("two-sample R4");
    check("two-sample R4 idx 4", int'(fail_idx), 4);
  endtask

  task automatic t_busy_ignore();
    int ef, ei;
    idle();
    start = 1;
    @(negedge clk);
    start = 0; clr = 1; in_valid = 1; in_idx = 0; in_cls = 0; in_sample = 255;
    for (int k = 0; k < 5; k++) @(negedge clk);
    start = 1;
    while (busy) @(negedge clk);
    clr = 0; in_valid = 0; start = 0;
    @(negedge clk);
    check("busy R7 no restart", int'(busy), 0);
    run_scan("busy R7 rescan");
    ref_verdict(ef, ei);
    check("busy R7 still idx 4", int'(fail_idx), 4);
  endtask

  task automatic t_clear();
    do_clear();
    run_scan("clear R8");
    check("clear R8 pass", int'(fail), 0);
  endtask

  task automatic t_saturate();
    do_clear();
    for (int k = 0; k < CMAX; k++) push(0, 0, 100);
    for (int k = 0; k < CMAX; k++) push(0, 1, (k % 2) ? 101 : 99);
    for (int k = 0; k < 300; k++) push(0, 0, 255);
    run_scan("sat R9");
    check("sat R9 dropped", int'(fail), 0);
  endtask

  task automatic t_hold();
    for (int k = 0; k < 20; k++) push(3, 0, 255);
    idle();
    check("hold R10 fail", int'(fail), 0);
    check("hold R10 idx", int'(fail_idx), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    ref_clear();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_same_dist();
    t_one_shift();
    t_two_shifts();
    t_edge();
    t_small();
    t_busy_ignore();
    t_clear();
    t_saturate();
    t_hold();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end
endmodule